// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block computes memory addresses for a DSP-style datapath without using any arithmetic unit cycles. It holds four banks of eight registers each: pointers, modifiers, buffer lengths and buffer bases. Each clock, a request names one pointer, one modifier and an access mode.

In pre-modify mode the issued address is the pointer plus the modifier, and the pointer keeps its value. In post-modify mode the issued address is the pointer itself, and the pointer is then advanced by the modifier. The advance wraps inside the circular buffer set by that pointer's base and length registers. The address width is a parameter, so the same unit serves a wide data-memory port and a narrower program-memory port. Two instances share no state, so they can issue independent addresses in the same cycle.

A write port loads any register in any bank. A combinational readback port returns any register. Loading a base register also starts the matching pointer at that base.

Top module: `dag_unit`

## Requirements
- R1: After a synchronous active-low reset, every register in all four banks reads back as zero, `addr_valid` is 0 and `addr_out` is 0.
- R2: A pre-modify request (`req_post`=0) issues pointer + modifier modulo 2^AW and leaves the selected pointer unchanged.
- R3: A post-modify request (`req_post`=1) issues the current pointer value as the address and writes the advanced value back to that pointer.
- R4: When the selected pointer's length register is zero, the post-modify advance is plain addition of the modifier modulo 2^AW, with no wrapping.
- R5: When the length L is nonzero and the pointer lies in [base, base+L-1], a post-modify advance with a modifier of magnitude at most L subtracts L if the sum reaches base+L or more. A sum of exactly base+L therefore returns to base.
- R6: Under the same conditions as R5, a negative (two's complement) modifier whose sum falls below base adds L.
- R7: The write port loads `wr_data` into register `wr_idx` of the bank chosen by `wr_sel` (0 = pointer, 1 = modifier, 2 = length, 3 = base) at the clock edge. `rd_data` shows register `rd_idx` of bank `rd_sel`, with the same bank codes, combinationally.
- R8: Writing a base register also loads the same value into the pointer of the same index.
- R9: When a register write (pointer or base bank) and a post-modify update target the same pointer in the same cycle, the written value is kept. The request still issues the pointer value from before the edge.
- R10: `addr_out` and `addr_valid` are registered. `addr_valid` is 1 in exactly the cycle after each accepted request, and requests may come back to back on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address request this cycle |
| req_post | input | 1 | 1 = post-modify, 0 = pre-modify |
| req_ptr_idx | input | 3 | Pointer register used by the request |
| req_mod_idx | input | 3 | Modifier register used by the request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Bank to write (0 ptr, 1 mod, 2 len, 3 base) |
| wr_idx | input | 3 | Register index to write |
| wr_data | input | AW | Value to write |
| rd_sel | input | 2 | Bank to read back |
| rd_idx | input | 3 | Register index to read back |
| rd_data | output | AW | Readback value |
| addr_out | output | AW | Generated address |
| addr_valid | output | 1 | `addr_out` holds a new address |

## Verification
A wrong internal pointer cannot be seen directly. It shows up on `addr_out` one cycle after the next post-modify request that uses that pointer, or after a pre-modify request as an offset address. It also shows up at once on `rd_data` when that pointer is read back. A wrap error surfaces as an address outside the buffer on the following post-modify access. A lost write priority shows up as the advanced value instead of the written one on the next readback. A wrong modifier, length or base register corrupts the first address or update that uses it.

// File: rtl/dag_pkg.sv
// Package: shared bank codes for the address generator.
// Assumes: the four bank codes are fixed and shared by the write and readback ports.
package dag_pkg;
    typedef enum logic [1:0] {
        BANK_PTR  = 2'd0,
        BANK_MOD  = 2'd1,
        BANK_LEN  = 2'd2,
        BANK_BASE = 2'd3
    } bank_e;
endpackage

// File: rtl/dag_regfile.sv
// Module: dag_regfile
// Holds the pointer, modifier, length and base banks. The write port has
// priority over the post-modify update. A base write also seeds the pointer
// of the same index.
// Assumes: at most one pointer update per cycle; readback is combinational.
module dag_regfile
    import dag_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_sel,
    input  logic [IW-1:0]            wr_idx,
    input  logic [AW-1:0]            wr_data,
    input  logic                     upd_en,
    input  logic [IW-1:0]            upd_idx,
    input  logic [AW-1:0]            upd_val,
    input  logic [1:0]               rd_sel,
    input  logic [IW-1:0]            rd_idx,
    output logic [AW-1:0]            rd_data,
    output logic [NREG-1:0][AW-1:0]  ptr_o,
    output logic [NREG-1:0][AW-1:0]  mod_o,
    output logic [NREG-1:0][AW-1:0]  len_o,
    output logic [NREG-1:0][AW-1:0]  base_o
);

    logic [NREG-1:0][AW-1:0] ptr_q, mod_q, len_q, base_q;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_entry
            logic hit_ptr, hit_mod, hit_len, hit_base;
            assign hit_ptr  = wr_en && (wr_idx == IW'(g)) && (wr_sel == BANK_PTR);
            assign hit_mod  = wr_en && (wr_idx == IW'(g)) && (wr_sel == BANK_MOD);
            assign hit_len  = wr_en && (wr_idx == IW'(g)) && (wr_sel == BANK_LEN);
            assign hit_base = wr_en && (wr_idx == IW'(g)) && (wr_sel == BANK_BASE);

            // Pointer entry: explicit or base-seed write wins over the update.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ptr_q[g] <= '0;
                else if (hit_ptr || hit_base)
                    ptr_q[g] <= wr_data;
                else if (upd_en && (upd_idx == IW'(g)))
                    ptr_q[g] <= upd_val;
            end

            // Modifier, length and base entries: loaded only by the write port.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mod_q[g]  <= '0;
                    len_q[g]  <= '0;
                    base_q[g] <= '0;
                end else begin
                    if (hit_mod)  mod_q[g]  <= wr_data;
                    if (hit_len)  len_q[g]  <= wr_data;
                    if (hit_base) base_q[g] <= wr_data;
                end
            end
        end
    endgenerate

    // Readback multiplexer over the four banks.
    always_comb begin
        unique case (bank_e'(rd_sel))
            BANK_PTR:  rd_data = ptr_q[rd_idx];
            BANK_MOD:  rd_data = mod_q[rd_idx];
            BANK_LEN:  rd_data = len_q[rd_idx];
            default:   rd_data = base_q[rd_idx];
        endcase
    end

    assign ptr_o  = ptr_q;
    assign mod_o  = mod_q;
    assign len_o  = len_q;
    assign base_o = base_q;

    AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !wr_en) |=> $stable(ptr_q)); // R2

    AST_PTR_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == BANK_PTR) |=> (ptr_q[$past(wr_idx)] == $past(wr_data))); // R9

    AST_BASE_SEEDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == BANK_BASE) |=>
            (ptr_q[$past(wr_idx)] == $past(wr_data) && base_q[$past(wr_idx)] == $past(wr_data))); // R8

endmodule

// File: rtl/dag_wrap.sv
// Module: dag_wrap
// Combinational post-modify advance. With a zero length the result is the
// plain sum. Otherwise the offset from the base is moved by the signed
// modifier and folded back once into [0, len).
// Assumes: pointer lies inside its buffer, |modifier| <= length, and
// base+length does not pass 2^AW.
module dag_wrap #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] mod_i,
    input  logic [AW-1:0] len_i,
    input  logic [AW-1:0] base_i,
    output logic [AW-1:0] next_o
);

    logic [AW-1:0] offset;
    logic [AW+1:0] raw;
    logic          raw_neg;
    logic          raw_over;
    logic [AW-1:0] folded;

    // Fold the moved offset back into the buffer and rebase it.
    always_comb begin
        offset   = ptr_i - base_i;
        raw      = {2'b00, offset} + {{2{mod_i[AW-1]}}, mod_i};
        raw_neg  = raw[AW+1];
        raw_over = !raw_neg && (raw >= {2'b00, len_i});
        if (raw_neg)
            folded = raw[AW-1:0] + len_i;
        else if (raw_over)
            folded = raw[AW-1:0] - len_i;
        else
            folded = raw[AW-1:0];
        if (len_i == '0)
            next_o = ptr_i + mod_i;
        else
            next_o = base_i + folded;
    end

endmodule

// File: rtl/dag_addr_stage.sv
// Module: dag_addr_stage
// Output register for the generated address and its valid flag.
// Assumes: one request per clock; the address holds its value when idle.
module dag_addr_stage #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] addr_d,
    output logic [AW-1:0] addr_q,
    output logic          valid_q
);

    // Capture the address for each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= req_valid;
            if (req_valid)
                addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/dag_unit.sv
// Module: dag_unit
// Top of the address generator. Selects the pointer and modifier for the
// request, forms the pre- or post-modify address, drives the wrapped pointer
// update, and registers the address output.
// Assumes: the request reads register values from before the clock edge.
module dag_unit
    import dag_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_post,
    input  logic [IW-1:0] req_ptr_idx,
    input  logic [IW-1:0] req_mod_idx,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [1:0]    rd_sel,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_data,
    output logic [AW-1:0] addr_out,
    output logic          addr_valid
);

    logic [NREG-1:0][AW-1:0] ptr_all, mod_all, len_all, base_all;
    logic [AW-1:0] sel_ptr, sel_mod, sel_len, sel_base;
    logic [AW-1:0] next_ptr;
    logic [AW-1:0] addr_d;
    logic          upd_en;

    dag_regfile #(.AW(AW), .NREG(NREG)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .upd_idx (req_ptr_idx),
        .upd_val (next_ptr),
        .rd_sel  (rd_sel),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .ptr_o   (ptr_all),
        .mod_o   (mod_all),
        .len_o   (len_all),
        .base_o  (base_all)
    );

    // Pick the operands named by the request.
    always_comb begin
        sel_ptr  = ptr_all[req_ptr_idx];
        sel_mod  = mod_all[req_mod_idx];
        sel_len  = len_all[req_ptr_idx];
        sel_base = base_all[req_ptr_idx];
        upd_en   = req_valid && req_post;
        addr_d   = req_post ? sel_ptr : (sel_ptr + sel_mod);
    end

    dag_wrap #(.AW(AW)) wrap_i (
        .ptr_i  (sel_ptr),
        .mod_i  (sel_mod),
        .len_i  (sel_len),
        .base_i (sel_base),
        .next_o (next_ptr)
    );

    dag_addr_stage #(.AW(AW)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .addr_d    (addr_d),
        .addr_q    (addr_out),
        .valid_q   (addr_valid)
    );

    // Conditions under which the wrapped result must stay inside the buffer.
    logic [AW-1:0] mod_mag;
    logic          wrap_case;
    logic          ptr_overwritten;
    always_comb begin
        mod_mag         = sel_mod[AW-1] ? (~sel_mod + 1'b1) : sel_mod;
        ptr_overwritten = wr_en && (wr_idx == req_ptr_idx) &&
                          (wr_sel == BANK_PTR || wr_sel == BANK_BASE);
        wrap_case       = upd_en && !ptr_overwritten && (sel_len != '0) &&
                          (sel_ptr >= sel_base) && (sel_ptr - sel_base < sel_len) &&
                          (mod_mag <= sel_len);
    end

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid); // R10

    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid); // R10

    AST_WRAP_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_case |=> ((ptr_all[$past(req_ptr_idx)] >= $past(sel_base)) &&
                       (ptr_all[$past(req_ptr_idx)] - $past(sel_base) < $past(sel_len)))); // R5

    AST_POST_ISSUES_OLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_post) |=> (addr_out == $past(ptr_all[req_ptr_idx]))); // R3

endmodule

// File: tb/dag_unit_tb_top.sv
`timescale 1ns/100ps
module dag_unit_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_post;
    logic [2:0]    req_ptr_idx, req_mod_idx;
    logic          wr_en;
    logic [1:0]    wr_sel;
    logic [2:0]    wr_idx;
    logic [AW-1:0] wr_data;
    logic [1:0]    rd_sel;
    logic [2:0]    rd_idx;
    logic [AW-1:0] rd_data, addr_out;
    logic          addr_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] mreg [4][8];

    always #2 clk = ~clk;

    dag_unit #(.AW(AW), .NREG(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_post(req_post),
        .req_ptr_idx(req_ptr_idx), .req_mod_idx(req_mod_idx),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
        .addr_out(addr_out), .addr_valid(addr_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_rd(input string tag, input int sel, input int idx);
        rd_sel = 2'(sel);
        rd_idx = 3'(idx);
        #0.1;
        check(tag, rd_data, mreg[sel][idx]);
    endtask

    // Reference post-modify advance, written from the wrap rules.
    function automatic logic [31:0] advance(input logic [31:0] p, input logic [31:0] m,
                                            input logic [31:0] l, input logic [31:0] b);
        longint s;
        if (l == 0) return p + m;
        s = longint'(p) + longint'($signed(m));
        if (s < longint'(b)) s = s + longint'(l);
        else if (s >= longint'(b) + longint'(l)) s = s - longint'(l);
        return s[31:0];
    endfunction

    // One clock: drive at negedge, update the model at the edge, compare after it.
    task automatic cycle(input bit rv, input bit post, input int pi, input int mi,
                         input bit we, input int ws, input int wi, input logic [31:0] wd,
                         input string tag);
        logic [31:0] exp_addr;
        @(negedge clk);
        req_valid = rv; req_post = post; req_ptr_idx = 3'(pi); req_mod_idx = 3'(mi);
        wr_en = we; wr_sel = 2'(ws); wr_idx = 3'(wi); wr_data = wd;
        @(posedge clk);
        exp_addr = 0;
        if (rv) begin
            exp_addr = post ? mreg[0][pi] : mreg[0][pi] + mreg[1][mi];
            if (post) mreg[0][pi] = advance(mreg[0][pi], mreg[1][mi], mreg[2][pi], mreg[3][pi]);
        end
        if (we) begin
            mreg[ws][wi] = wd;
            if (ws == 3) mreg[0][wi] = wd;
        end
        #1;
        check("R10 addr_valid", {31'b0, addr_valid}, {31'b0, rv});
        if (rv) check(tag, addr_out, exp_addr);
        req_valid = 0; wr_en = 0;
    endtask

    task automatic wr(input int ws, input int wi, input logic [31:0] wd);
        cycle(0, 0, 0, 0, 1, ws, wi, wd, "R7");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int s = 0; s < 4; s++) for (int i = 0; i < 8; i++) mreg[s][i] = 0;
        rst_n = 0; req_valid = 0; req_post = 0; req_ptr_idx = 0; req_mod_idx = 0;
        wr_en = 0; wr_sel = 0; wr_idx = 0; wr_data = 0; rd_sel = 0; rd_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #0.5;
        // R1: reset state
        check("R1 addr_valid", {31'b0, addr_valid}, 32'd0);
        check("R1 addr_out", addr_out, 32'd0);
        for (int s = 0; s < 4; s++) for (int i = 0; i < 8; i++) check_rd("R1 regs", s, i);

        // R7: load modifiers and read back
        wr(1, 0, 32'd4);
        wr(1, 1, 32'hFFFF_FFFC);
        wr(1, 2, 32'd6);
        wr(1, 3, 32'd1);
        for (int i = 0; i < 4; i++) check_rd("R7 mod", 1, i);

        // R2: pre-modify, pointer kept
        wr(0, 0, 32'h100);
        check_rd("R7 ptr", 0, 0);
        cycle(1, 0, 0, 0, 0, 0, 0, 0, "R2 pre addr");
        cycle(1, 0, 0, 1, 0, 0, 0, 0, "R2 pre addr neg");
        check_rd("R2 ptr kept", 0, 0);
        check("R2 ptr literal", rd_data, 32'h100);

        // R3 and R4: post-modify linear, including modulo rollover
        cycle(1, 1, 0, 0, 0, 0, 0, 0, "R3 post addr");
        check_rd("R3 ptr advanced", 0, 0);
        check("R4 linear literal", rd_data, 32'h104);
        wr(0, 5, 32'hFFFF_FFFE);
        cycle(1, 1, 5, 0, 0, 0, 0, 0, "R3 post addr top");
        check_rd("R4 rollover", 0, 5);
        check("R4 rollover literal", rd_data, 32'd2);

        // R8: base write seeds pointer
        wr(2, 1, 32'd10);
        wr(3, 1, 32'h200);
        check_rd("R8 ptr seeded", 0, 1);
        check("R8 seed literal", rd_data, 32'h200);
        check_rd("R7 base", 3, 1);
        check_rd("R7 len", 2, 1);

        // R5: wrap upward, R6: wrap downward, exact boundary
        cycle(1, 1, 1, 2, 0, 0, 0, 0, "R5 post addr");
        cycle(1, 1, 1, 2, 0, 0, 0, 0, "R5 post addr");
        check_rd("R5 wrap", 0, 1);
        check("R5 wrap literal", rd_data, 32'h202);
        cycle(1, 1, 1, 1, 0, 0, 0, 0, "R6 post addr");
        check_rd("R6 wrap", 0, 1);
        check("R6 wrap literal", rd_data, 32'h208);
        wr(0, 1, 32'h206);
        cycle(1, 1, 1, 0, 0, 0, 0, 0, "R5 boundary addr");
        check_rd("R5 boundary", 0, 1);
        check("R5 boundary literal", rd_data, 32'h200);

        // R9: write priority over same-cycle update
        cycle(1, 1, 1, 0, 1, 0, 1, 32'h205, "R9 post addr old ptr");
        check_rd("R9 write kept", 0, 1);
        check("R9 literal", rd_data, 32'h205);
        cycle(1, 1, 1, 3, 1, 3, 1, 32'h200, "R9 base addr old ptr");
        check_rd("R9 base kept", 0, 1);

        // R10: idle cycle then back-to-back mixed traffic against the model
        cycle(0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            int pick, pi;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pick = int'(lfsr[1:0]);
            pi = (pick == 0) ? 7 : (pick == 1) ? 1 : 0;
            cycle(lfsr[2] | lfsr[3], lfsr[4], pi, int'(lfsr[6:5]),
                  lfsr[9:7] == 3'd0, 0, 0, {16'h0, lfsr}, lfsr[4] ? "R3 mixed" : "R2 mixed");
        end
        for (int s = 0; s < 4; s++) for (int i = 0; i < 8; i++) check_rd("R7 final", s, i);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule